// File: doc/BRIEF.md
# DMA Channel Byte-Count and Status Register

This block holds the remaining-byte count and the completion and error status of one DMA channel. Software programs the count and reads the status through a small register port. A transfer engine drives the channel through three strobes: start, one beat per completed transfer (with its size), and bus error. The count is 24 bits wide, but only values up to 0x0FFFFF are legal. An oversize value is accepted when written and is marked in the upper nibble on readback. The fault is raised later, when the channel is started.

The done flag has three sources: the count running out on a good transfer, a bus error, or a configuration fault at start. Writing a one to the done flag clears every status flag in one step. The same write stops a channel that is running, so software uses it both to acknowledge completion and to abort. The interrupt request is the done flag gated by an enable bit that sits at bit 31 of the control word.

Register map. Address 0 is the status/count word:
- bits 23:0 hold the count;
- bit 24 is done;
- bit 25 is busy;
- bit 26 is the bus-error flag;
- bit 27 is the configuration-error flag;
- bits 31:28 read as zero.

Address 1 is the control word. Only bit 31, the interrupt enable, is stored. The other control bits read as zero.

Top module: `dma_bcnt_stat`

## Requirements
- R1: After reset, busy and irq are 0 and both register words read as 0.
- R2: A count write of at most 0x0FFFFF (address 0, bit 24 = 0, channel not busy) reads back with bits 23:20 = 0000b and bits 19:0 as written, and all flag bits 0.
- R3: A count write above 0x0FFFFF is accepted without fault: it reads back with bits 23:20 = 0001b and bits 19:0 as written, with bits 24 and 27 still 0.
- R4: A start while not busy and not done, with an oversize count, sets the configuration-error flag (bit 27) and done (bit 24) on the next edge and leaves busy 0.
- R5: A start while not busy and not done, with a legal nonzero count, sets busy on the next edge. A start with a legal count of zero sets done at once without busy. A start while done is 1 is ignored.
- R6: Each transfer strobe while busy subtracts the size: code 0 = 1 byte, code 1 = 2 bytes, codes 2 and 3 = 4 bytes. A step at or above the remaining count leaves 0, sets done and clears busy.
- R7: A bus-error strobe while busy sets done and the bus-error flag (bit 26), clears busy and holds the count. It wins over a transfer strobe in the same cycle.
- R8: A write to address 0 with bit 24 = 1 clears done, busy and both error flags at once, stopping the channel and leaving the count unchanged. A write with bit 24 = 0 leaves the flags unchanged.
- R9: A count write while busy is ignored.
- R10: Bit 31 of address 1 is the interrupt enable and reads back as written; irq equals the enable ANDed with done.
- R11: Transfer and bus-error strobes while not busy change neither count nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = status/count word, 1 = control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid one edge after reg_rd |
| eng_start | input | 1 | Channel start request from the engine |
| eng_xfer | input | 1 | One transfer completed |
| eng_size | input | 2 | Size code of the completed transfer |
| eng_err | input | 1 | Bus error on the current transfer |
| busy | output | 1 | Channel running |
| irq | output | 1 | Interrupt request |

## Verification
Every strobe and write takes effect at the next rising edge, so busy and irq show the result one edge after the stimulus. A register read strobe returns data at the edge after it. The bench drives each input on a falling edge and samples results at the next falling edge, which lies after exactly one rising edge. Each read is issued as its own strobe after the event it observes, so each read costs one more edge.

// File: rtl/dma_bcnt_pkg.sv
package dma_bcnt_pkg;

  localparam int DW       = 32;
  localparam int CNT_W    = 24;
  localparam int LEGAL_W  = 20;
  localparam int STEP_W   = 3;
  localparam int DONE_BIT = CNT_W;
  localparam int BUSY_BIT = CNT_W + 1;
  localparam int BERR_BIT = CNT_W + 2;
  localparam int CERR_BIT = CNT_W + 3;
  localparam int IEN_BIT  = DW - 1;

  typedef enum logic [1:0] {
    XSZ_BYTE = 2'd0,
    XSZ_HALF = 2'd1,
    XSZ_WORD = 2'd2,
    XSZ_WRSV = 2'd3
  } xfer_size_e;

  typedef struct packed {
    logic cfg_err;
    logic bus_err;
    logic busy;
    logic done;
  } stat_t;

  function automatic logic [STEP_W-1:0] step_of(input logic [1:0] code);
    case (xfer_size_e'(code))
      XSZ_BYTE: step_of = STEP_W'(1);
      XSZ_HALF: step_of = STEP_W'(2);
      default:  step_of = STEP_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/dma_bcnt_counter.sv
module dma_bcnt_counter #(
  parameter int CNT_W   = 24,
  parameter int LEGAL_W = 20,
  parameter int STEP_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               dec,
  input  logic [STEP_W-1:0]  step,
  output logic [LEGAL_W-1:0] cnt_q,
  output logic               over_q,
  output logic               is_zero,
  output logic               last_beat
);

  logic [LEGAL_W-1:0] step_ext;

  assign step_ext  = LEGAL_W'(step);
  assign last_beat = (step_ext >= cnt_q);
  assign is_zero   = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val[LEGAL_W-1:0];
      over_q <= |load_val[CNT_W-1:LEGAL_W];
    end else if (dec) begin
      cnt_q  <= last_beat ? '0 : (cnt_q - step_ext);
    end
  end

endmodule

// File: rtl/dma_bcnt_status.sv
module dma_bcnt_status
  import dma_bcnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clr_all,
  input  logic  start,
  input  logic  xfer,
  input  logic  err,
  input  logic  over,
  input  logic  cnt_zero,
  input  logic  last_beat,
  output stat_t st_q,
  output logic  dec_en
);

  stat_t st_d;

  assign dec_en = st_q.busy && xfer && !err && !clr_all;

  always_comb begin
    st_d = st_q;
    if (clr_all) begin
      st_d = '0;
    end else if (st_q.busy) begin
      if (err) begin
        st_d.busy    = 1'b0;
        st_d.done    = 1'b1;
        st_d.bus_err = 1'b1;
      end else if (xfer && last_beat) begin
        st_d.busy = 1'b0;
        st_d.done = 1'b1;
      end
    end else if (start && !st_q.done) begin
      if (over) begin
        st_d.cfg_err = 1'b1;
        st_d.done    = 1'b1;
      end else if (cnt_zero) begin
        st_d.done = 1'b1;
      end else begin
        st_d.busy = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/dma_bcnt_rdport.sv
module dma_bcnt_rdport #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          addr,
  input  logic [DW-1:0] stat_word,
  input  logic [DW-1:0] ctrl_word,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= addr ? ctrl_word : stat_word;
  end

endmodule

// File: rtl/dma_bcnt_stat.sv
module dma_bcnt_stat
  import dma_bcnt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_start,
  input  logic          eng_xfer,
  input  logic [1:0]    eng_size,
  input  logic          eng_err,
  output logic          busy,
  output logic          irq
);

  localparam int HI_W  = CNT_W - LEGAL_W;
  localparam int PAD_W = DW - CNT_W - 4;

  stat_t              st;
  logic               wr_stat, clr_all, cnt_load, dec_en;
  logic               ien_q, over_q, cnt_zero, last_beat;
  logic [LEGAL_W-1:0] cnt_q;
  logic [STEP_W-1:0]  step;
  logic [DW-1:0]      stat_word, ctrl_word;
  logic [CNT_W-1:0]   cnt_view;

  assign wr_stat  = reg_wr && (reg_addr == 1'b0);
  assign clr_all  = wr_stat && reg_wdata[DONE_BIT];
  assign cnt_load = wr_stat && !reg_wdata[DONE_BIT] && !st.busy;
  assign step     = step_of(eng_size);

  always_ff @(posedge clk) begin
    if (rst)                        ien_q <= 1'b0;
    else if (reg_wr && reg_addr)    ien_q <= reg_wdata[IEN_BIT];
  end

  dma_bcnt_counter #(
    .CNT_W  (CNT_W),
    .LEGAL_W(LEGAL_W),
    .STEP_W (STEP_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (reg_wdata[CNT_W-1:0]),
    .dec      (dec_en),
    .step     (step),
    .cnt_q    (cnt_q),
    .over_q   (over_q),
    .is_zero  (cnt_zero),
    .last_beat(last_beat)
  );

  dma_bcnt_status u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (clr_all),
    .start    (eng_start),
    .xfer     (eng_xfer),
    .err      (eng_err),
    .over     (over_q),
    .cnt_zero (cnt_zero),
    .last_beat(last_beat),
    .st_q     (st),
    .dec_en   (dec_en)
  );

  assign cnt_view  = {{(HI_W-1){1'b0}}, over_q, cnt_q};
  assign stat_word = {{PAD_W{1'b0}}, st.cfg_err, st.bus_err, st.busy, st.done, cnt_view};
  assign ctrl_word = {ien_q, {(DW-1){1'b0}}};

  dma_bcnt_rdport #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .stat_word(stat_word),
    .ctrl_word(ctrl_word),
    .rdata    (reg_rdata)
  );

  assign busy = st.busy;
  assign irq  = ien_q && st.done;

endmodule

// File: rtl/dma_bcnt_chk.sv
module dma_bcnt_chk
  import dma_bcnt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic               eng_start,
  input logic               eng_xfer,
  input logic               eng_err,
  input logic               busy_q,
  input logic               done_q,
  input logic               berr_q,
  input logic               cerr_q,
  input logic               over_q,
  input logic [LEGAL_W-1:0] cnt_q,
  input logic               irq
);

  logic clr;
  assign clr = reg_wr && !reg_addr && reg_wdata[DONE_BIT];

  // R8
  a_r8_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!done_q && !busy_q && !berr_q && !cerr_q));

  // R4
  a_r4_cfg_at_start: assert property (@(posedge clk) disable iff (rst)
    (eng_start && !busy_q && !done_q && over_q && !clr) |=> (cerr_q && done_q && !busy_q));

  // R3
  a_r3_no_cfg_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(cerr_q) |-> $past(eng_start));

  // R6
  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy_q && done_q));

  // R7
  a_r7_err_stops: assert property (@(posedge clk) disable iff (rst)
    (busy_q && eng_err && !clr) |=> (done_q && berr_q && !busy_q && $stable(cnt_q)));

  // R9
  a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !eng_xfer) |=> $stable(cnt_q));

  // R11
  a_r11_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !eng_start) |=> !busy_q);

  // R10
  a_r10_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_q);

endmodule

bind dma_bcnt_stat dma_bcnt_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .eng_start(eng_start),
  .eng_xfer (eng_xfer),
  .eng_err  (eng_err),
  .busy_q   (st.busy),
  .done_q   (st.done),
  .berr_q   (st.bus_err),
  .cerr_q   (st.cfg_err),
  .over_q   (over_q),
  .cnt_q    (cnt_q),
  .irq      (irq)
);

// File: tb/dma_bcnt_stat_tb.sv
`timescale 1ns/1ps
module dma_bcnt_stat_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_start = 1'b0, eng_xfer = 1'b0, eng_err = 1'b0;
  logic [1:0]  eng_size = 2'd0;
  logic        busy, irq;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  dma_bcnt_stat u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_xfer(eng_xfer), .eng_size(eng_size), .eng_err(eng_err),
    .busy(busy), .irq(irq)
  );

  function automatic logic [31:0] sw(input bit cerr, input bit berr, input bit bsy,
                                     input bit dn, input logic [23:0] cnt);
    return {4'b0, cerr, berr, bsy, dn, cnt};
  endfunction

  function automatic logic [23:0] view(input logic [23:0] v);
    return {3'b0, (v > 24'h0FFFFF), v[19:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic start;
    eng_start = 1'b1; @(negedge clk); eng_start = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] sz, input bit with_err);
    eng_xfer = 1'b1; eng_size = sz; eng_err = with_err;
    @(negedge clk);
    eng_xfer = 1'b0; eng_err = 1'b0;
  endtask

  task automatic err_only;
    eng_err = 1'b1; @(negedge clk); eng_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [23:0] vals[8];
    vals = '{24'h000000, 24'h000001, 24'h012345, 24'h0FFFFF,
             24'h080000, 24'h100000, 24'hABCDEF, 24'hFFFFFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 irq", 32'(irq), 0);
    rd(1'b0, d); check("R1 status word", d, 0);
    rd(1'b1, d); check("R1 control word", d, 0);

    // R2 / R3 count readback sweep
    foreach (vals[i]) begin
      wr(1'b0, {8'h00, vals[i]});
      rd(1'b0, d);
      check(vals[i] > 24'h0FFFFF ? "R3 oversize readback" : "R2 legal readback",
            d, sw(0, 0, 0, 0, view(vals[i])));
    end

    // R4 oversize start, then R8 clear keeps count
    wr(1'b0, 32'h001ABCDE);
    start;
    check("R4 busy stays low", 32'(busy), 0);
    rd(1'b0, d); check("R4 cfg error and done", d, sw(1, 0, 0, 1, 24'h1ABCDE));
    check("R10 irq off when disabled", 32'(irq), 0);
    wr(1'b0, 32'h01000000);
    rd(1'b0, d); check("R8 clear keeps count", d, sw(0, 0, 0, 0, 24'h1ABCDE));

    // R10 interrupt enable
    wr(1'b1, 32'h80000000);
    rd(1'b1, d); check("R10 enable readback", d, 32'h80000000);
    wr(1'b0, 32'd2);
    start;
    check("R5 busy after start", 32'(busy), 1);
    check("R10 irq low while busy", 32'(irq), 0);
    xfer(2'd1, 0);
    check("R10 irq on done", 32'(irq), 1);
    wr(1'b0, 32'h01000000);
    check("R10 irq cleared", 32'(irq), 0);
    wr(1'b1, 32'h0);

    // R6 decrement sweep over all size codes and small counts
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 1; n <= 7; n++) begin
        int c, s;
        c = n;
        s = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        wr(1'b0, 32'(n));
        start;
        check("R5 busy on legal start", 32'(busy), 1);
        while (c != 0) begin
          xfer(2'(sz), 0);
          c = (s >= c) ? 0 : c - s;
          rd(1'b0, d);
          check("R6 count step", d, sw(0, 0, (c != 0), (c == 0), 24'(c)));
        end
        wr(1'b0, 32'h01000000);
      end
    end

    // R5 zero count start, start while done ignored
    wr(1'b0, 32'd0);
    start;
    check("R5 zero count no busy", 32'(busy), 0);
    rd(1'b0, d); check("R5 zero count done", d, sw(0, 0, 0, 1, 0));
    wr(1'b0, 32'd5);
    rd(1'b0, d); check("R8 write zero keeps done", d, sw(0, 0, 0, 1, 5));
    start;
    check("R5 start ignored while done", 32'(busy), 0);
    rd(1'b0, d); check("R5 state after ignored start", d, sw(0, 0, 0, 1, 5));
    wr(1'b0, 32'h01000000);

    // R7 bus error
    wr(1'b0, 32'd10);
    start;
    xfer(2'd0, 0);
    err_only;
    check("R7 busy cleared", 32'(busy), 0);
    rd(1'b0, d); check("R7 error holds count", d, sw(0, 1, 0, 1, 9));
    wr(1'b0, 32'h01000000);
    wr(1'b0, 32'd10);
    start;
    xfer(2'd2, 1);
    rd(1'b0, d); check("R7 error wins over transfer", d, sw(0, 1, 0, 1, 10));
    wr(1'b0, 32'h01000000);

    // R9 write while busy, R8 abort, R11 idle strobes
    wr(1'b0, 32'd10);
    start;
    wr(1'b0, 32'd3);
    rd(1'b0, d); check("R9 write ignored while busy", d, sw(0, 0, 1, 0, 10));
    wr(1'b0, 32'h01000000);
    check("R8 abort stops channel", 32'(busy), 0);
    rd(1'b0, d); check("R8 abort clears flags", d, sw(0, 0, 0, 0, 10));
    xfer(2'd2, 0);
    err_only;
    rd(1'b0, d); check("R11 idle strobes ignored", d, sw(0, 0, 0, 0, 10));

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule